// File: doc/BRIEF.md
# Asymmetric Four-Lane Instruction Decode Stage

This block is the decode stage of a two-thread front end. Each cycle it looks at a window of up to four pre-decoded instructions from one hardware thread, turns them into fixed-format micro-ops, and registers the result as a four-slot output bundle. Lane 0 is the complex decoder and can expand one instruction into one to four micro-ops. Lanes 1 to 3 are simple decoders that each handle one single-micro-op instruction. Every extra micro-op that lane 0 produces takes away one simple lane, so the bundle never holds more than four micro-ops.

An instruction that needs more than four micro-ops is handed to a small sequencer ROM. The sequencer streams up to four micro-ops per cycle until its last row, and all decode lanes stay idle for that time. The block tells the instruction queue how many instructions it consumed through a combinational count. The queue keeps the rest in program order and presents them again, with the first unconsumed instruction in lane 0. A downstream stall freezes the bundle, the thread pointer and the sequencer.

Opcodes are 4-bit class indices with no further meaning. Lookup functions give the micro-op count of each class and the length of each microcoded sequence.

Top module: `asym_decode_stage`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the output bundle is empty (`out_vld` = 0, `out_tid` = 0), `cur_tid` is 0 and no sequence is in progress.
- R2: On every cycle with no stall and no active sequence, the decoded thread (`cur_tid`) flips; it never changes in any other cycle.
- R3: The lane-0 instruction fills bundle slots 0..k-1, where k = 1 for opcodes 0-7, 2 for opcodes 8-9, 3 for opcodes 10-11 and 4 for opcode 12; slot j carries the opcode and micro-op ordinal j in `out_idx`, and `out_tid` names the decoded thread.
- R4: After lane 0, at most 4-k further instructions are accepted, in order, each only if it is a single-micro-op opcode (0-7), and each is placed in the next free slot with ordinal 0.
- R5: A multi-micro-op or microcoded opcode in lane 1, 2 or 3 ends acceptance in front of it, so it sits in lane 0 of the next window of that thread.
- R6: Opcodes 13, 14 and 15 are microcoded with N = 5 + 3*(op-13) micro-ops (5, 8 and 11). Such an instruction is accepted only in lane 0, alone. It yields ceil(N/4) bundles on consecutive unstalled cycles, the first on the accepting cycle, each holding min(4, remaining) micro-ops with ordinals running on from 4 times the row number.
- R7: While a microcoded sequence is streaming, `take_cnt` is 0, no instruction is decoded and `cur_tid` holds.
- R8: While `out_stall` is high, the registered bundle keeps its value, `take_cnt` is 0, and neither the thread pointer nor the sequencer moves.
- R9: `take_cnt` equals the number of leading window instructions accepted this cycle (0 when lane 0 is empty). Valid bits of each thread window form a prefix starting at lane 0; thread t lane l sits at `in_vld[t*4+l]` and `in_op[(t*4+l)*4 +: 4]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 8 | Window valid bits, thread-major, lane-minor |
| in_op | input | 32 | Window opcodes, 4 bits per slot, same order |
| out_stall | input | 1 | Downstream backpressure |
| take_cnt | output | 3 | Instructions consumed from the thread named by `cur_tid` this cycle |
| cur_tid | output | 1 | Thread whose window is decoded this cycle |
| out_vld | output | 4 | Bundle slot valid bits |
| out_op | output | 16 | Bundle slot opcodes, 4 bits per slot |
| out_idx | output | 16 | Micro-op ordinal within its instruction, 4 bits per slot |
| out_tid | output | 1 | Thread that owns the bundle |

## Verification
The assertions assume that each thread window presents its valid instructions as an unbroken run starting at lane 0, and that a queue pops exactly `take_cnt` entries from the thread named by `cur_tid`. The stimulus builds both windows straight from per-thread queues that pop that count, so gaps never appear. Windows shorter than four arise only when a queue drains. The stall pattern is independent of bundle contents, so stalls land in the middle of microcoded sequences as well as on plain decode cycles.

// File: rtl/udec_pkg.sv
package udec_pkg;
  localparam int LANES     = 4;
  localparam int THREADS   = 2;
  localparam int OPW       = 4;
  localparam int IDXW      = 4;
  localparam int CW        = $clog2(LANES + 1);
  // opcode class boundaries
  localparam int ONE_END   = 8;
  localparam int TWO_END   = 10;
  localparam int THREE_END = 12;
  localparam int MS_FIRST  = 13;
  // microcoded length = MS_BASE + MS_STEP * (op - MS_FIRST)
  localparam int MS_BASE   = 5;
  localparam int MS_STEP   = 3;
  localparam int MS_ROWS   = 4;

  function automatic logic is_ucode(input logic [OPW-1:0] op);
    return int'(op) >= MS_FIRST;
  endfunction

  function automatic logic [CW-1:0] uop_count(input logic [OPW-1:0] op);
    if (int'(op) < ONE_END)        return CW'(1);
    else if (int'(op) < TWO_END)   return CW'(2);
    else if (int'(op) < THREE_END) return CW'(3);
    else                           return CW'(LANES);
  endfunction
endpackage

// File: rtl/udec_tsel.sv
module udec_tsel (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic tid
);
  always_ff @(posedge clk) begin
    if (rst)      tid <= 1'b0;
    else if (adv) tid <= ~tid;
  end

  // R2
  tid_flip_chk: assert property (@(posedge clk) disable iff (rst)
    adv |=> (tid != $past(tid)));
  // R7
  tid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(tid));
endmodule

// File: rtl/udec_lane_alloc.sv
module udec_lane_alloc
  import udec_pkg::*;
(
  input  logic [LANES-1:0]           vld,
  input  logic [LANES-1:0][OPW-1:0]  ops,
  output logic [CW-1:0]              take,
  output logic                       ms_start,
  output logic [LANES-1:0]           b_vld,
  output logic [LANES-1:0][OPW-1:0]  b_op,
  output logic [LANES-1:0][IDXW-1:0] b_idx
);
  always_comb begin : alloc
    int  k;
    logic stop;
    take     = '0;
    ms_start = 1'b0;
    b_vld    = '0;
    b_op     = '0;
    b_idx    = '0;
    k        = 0;
    stop     = 1'b0;
    if (vld[0]) begin
      take = CW'(1);
      if (is_ucode(ops[0])) begin
        ms_start = 1'b1;
      end else begin
        k = int'(uop_count(ops[0]));
        for (int j = 0; j < LANES; j++) begin
          if (j < k) begin
            b_vld[j] = 1'b1;
            b_op[j]  = ops[0];
            b_idx[j] = IDXW'(j);
          end
        end
        for (int i = 1; i < LANES; i++) begin
          if (!stop && (i <= LANES - k) && vld[i] && !is_ucode(ops[i]) &&
              (uop_count(ops[i]) == CW'(1))) begin
            b_vld[k+i-1] = 1'b1;
            b_op[k+i-1]  = ops[i];
            b_idx[k+i-1] = '0;
            take         = take + CW'(1);
          end else begin
            stop = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/udec_useq.sv
module udec_useq
  import udec_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  logic            start,
  input  logic [OPW-1:0]  start_op,
  input  logic            start_tid,
  output logic            busy,
  output logic [OPW-1:0]  row_op,
  output logic [CW-1:0]   row_cnt,
  output logic [IDXW-1:0] row_base,
  output logic            row_tid
);
  localparam int NMS   = (1 << OPW) - MS_FIRST;
  localparam int MSW   = (NMS > 1) ? $clog2(NMS) : 1;
  localparam int STW   = $clog2(MS_ROWS);
  localparam int DEPTH = (1 << MSW) * MS_ROWS;

  logic [CW:0]    rom [DEPTH];
  logic [OPW-1:0] op_q;
  logic [STW-1:0] step_q;
  logic           tid_q;
  logic [STW-1:0] cur_step;
  logic [MSW-1:0] ms_sel;
  logic [CW:0]    entry;
  logic           row_end;

  for (genvar m = 0; m < (1 << MSW); m++) begin : g_seq
    for (genvar s = 0; s < MS_ROWS; s++) begin : g_row
      localparam int N    = MS_BASE + MS_STEP * m;
      localparam int REM  = N - LANES * s;
      localparam int CNT  = (m >= NMS || REM <= 0) ? 0 : ((REM > LANES) ? LANES : REM);
      localparam bit LAST = (m < NMS) && (REM > 0) && (REM <= LANES);
      assign rom[m*MS_ROWS+s] = {LAST, CW'(CNT)};
    end
  end

  assign row_op   = busy ? op_q : start_op;
  assign cur_step = busy ? step_q : '0;
  assign ms_sel   = MSW'(row_op - OPW'(MS_FIRST));
  assign entry    = rom[{ms_sel, cur_step}];
  assign row_cnt  = entry[CW-1:0];
  assign row_end  = entry[CW];
  assign row_base = IDXW'(cur_step) * IDXW'(LANES);
  assign row_tid  = busy ? tid_q : start_tid;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      op_q   <= '0;
      step_q <= '0;
      tid_q  <= 1'b0;
    end else if (adv) begin
      if (busy) begin
        if (row_end) busy <= 1'b0;
        else         step_q <= step_q + STW'(1);
      end else if (start && !row_end) begin
        busy   <= 1'b1;
        op_q   <= start_op;
        step_q <= STW'(1);
        tid_q  <= start_tid;
      end
    end
  end

  // R6
  seq_cont_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && adv && !row_end) |=> busy);
  // R6
  seq_row_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (row_cnt != '0));
  // R8
  seq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(busy) && $stable(step_q)));
endmodule

// File: rtl/asym_decode_stage.sv
module asym_decode_stage
  import udec_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic [THREADS*LANES-1:0]      in_vld,
  input  logic [THREADS*LANES*OPW-1:0]  in_op,
  input  logic                          out_stall,
  output logic [CW-1:0]                 take_cnt,
  output logic                          cur_tid,
  output logic [LANES-1:0]              out_vld,
  output logic [LANES*OPW-1:0]          out_op,
  output logic [LANES*IDXW-1:0]         out_idx,
  output logic                          out_tid
);
  logic [LANES-1:0]           win_vld;
  logic [LANES-1:0][OPW-1:0]  win_op;
  logic [CW-1:0]              a_take;
  logic                       a_ms;
  logic [LANES-1:0]           a_vld;
  logic [LANES-1:0][OPW-1:0]  a_op;
  logic [LANES-1:0][IDXW-1:0] a_idx;
  logic                       busy, adv_dec, row_tid;
  logic [OPW-1:0]             row_op;
  logic [CW-1:0]              row_cnt;
  logic [IDXW-1:0]            row_base;
  logic [LANES-1:0]           n_vld, vld_q;
  logic [LANES-1:0][OPW-1:0]  n_op, op_q;
  logic [LANES-1:0][IDXW-1:0] n_idx, idx_q;
  logic                       n_tid, tid_q;

  assign adv_dec = !out_stall && !busy;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      win_vld[l] = in_vld[int'(cur_tid)*LANES + l];
      win_op[l]  = in_op[(int'(cur_tid)*LANES + l)*OPW +: OPW];
    end
  end

  udec_tsel tsel_i (.clk(clk), .rst(rst), .adv(adv_dec), .tid(cur_tid));

  udec_lane_alloc alloc_i (
    .vld(win_vld), .ops(win_op), .take(a_take), .ms_start(a_ms),
    .b_vld(a_vld), .b_op(a_op), .b_idx(a_idx)
  );

  udec_useq useq_i (
    .clk(clk), .rst(rst), .adv(!out_stall), .start(adv_dec && a_ms),
    .start_op(win_op[0]), .start_tid(cur_tid), .busy(busy), .row_op(row_op),
    .row_cnt(row_cnt), .row_base(row_base), .row_tid(row_tid)
  );

  assign take_cnt = adv_dec ? a_take : '0;

  always_comb begin
    n_vld = '0;
    n_op  = '0;
    n_idx = '0;
    n_tid = cur_tid;
    if (busy || a_ms) begin
      n_tid = row_tid;
      for (int j = 0; j < LANES; j++) begin
        if (j < int'(row_cnt)) begin
          n_vld[j] = 1'b1;
          n_op[j]  = row_op;
          n_idx[j] = row_base + IDXW'(j);
        end
      end
    end else begin
      n_vld = a_vld;
      n_op  = a_op;
      n_idx = a_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      op_q  <= '0;
      idx_q <= '0;
      tid_q <= 1'b0;
    end else if (!out_stall) begin
      vld_q <= n_vld;
      op_q  <= n_op;
      idx_q <= n_idx;
      tid_q <= n_tid;
    end
  end

  assign out_vld = vld_q;
  assign out_op  = op_q;
  assign out_idx = idx_q;
  assign out_tid = tid_q;

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_stall |=> ($stable(out_vld) && $stable(out_op) && $stable(out_idx) && $stable(out_tid)));
  // R3
  bundle_packed_chk: assert property (@(posedge clk) disable iff (rst)
    ((out_vld & (out_vld + 1'b1)) == '0));
  // R7
  seq_emits_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !out_stall) |=> out_vld[0]);
  // R9
  win_prefix0_chk: assert property (@(posedge clk) disable iff (rst)
    ((in_vld[LANES-1:0] & (in_vld[LANES-1:0] + 1'b1)) == '0));
  // R9
  win_prefix1_chk: assert property (@(posedge clk) disable iff (rst)
    ((in_vld[2*LANES-1:LANES] & (in_vld[2*LANES-1:LANES] + 1'b1)) == '0));
endmodule

// File: tb/asym_decode_stage_tb.sv
module asym_decode_stage_tb_top;
  import udec_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [THREADS*LANES-1:0]     in_vld;
  logic [THREADS*LANES*OPW-1:0] in_op;
  logic                         out_stall;
  logic [CW-1:0]                take_cnt;
  logic                         cur_tid;
  logic [LANES-1:0]             out_vld;
  logic [LANES*OPW-1:0]         out_op;
  logic [LANES*IDXW-1:0]        out_idx;
  logic                         out_tid;

  always #2 clk = ~clk;

  asym_decode_stage dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_op(in_op), .out_stall(out_stall),
    .take_cnt(take_cnt), .cur_tid(cur_tid), .out_vld(out_vld), .out_op(out_op),
    .out_idx(out_idx), .out_tid(out_tid)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int qop[2][256];
  int qlen[2], qh[2];
  int m_tid, m_busy, m_op, m_step, m_stid, m_seqc;
  int e_vld[4], e_op[4], e_idx[4], e_tid;
  string e_tag;

  task automatic chk(string tag, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int ms_len(int op);
    return 5 + 3 * (op - 13);
  endfunction

  function automatic int ops_of(int op);
    if (op < 8)  return 1;
    if (op < 10) return 2;
    if (op < 12) return 3;
    return 4;
  endfunction

  task automatic check_bundle();
    for (int j = 0; j < 4; j++) begin
      chk(e_tag, int'(out_vld[j]), e_vld[j], $sformatf("slot%0d valid", j));
      chk(e_tag, int'(out_op[j*4 +: 4]), e_op[j], $sformatf("slot%0d op", j));
      chk(e_tag, int'(out_idx[j*4 +: 4]), e_idx[j], $sformatf("slot%0d ordinal", j));
    end
    chk(e_tag, int'(out_tid), e_tid, "bundle thread");
  endtask

  task automatic clear_exp();
    for (int j = 0; j < 4; j++) begin
      e_vld[j] = 0; e_op[j] = 0; e_idx[j] = 0;
    end
  endtask

  // called at a negedge; leaves at the next negedge
  task automatic run_cycle(int cyc);
    int v[4], o[4];
    int s, take, k, n, rem, cnt, t, go;
    string ttag;
    check_bundle();
    s = ((cyc % 7) == 5 || (cyc % 13) == 0) ? 1 : 0;
    out_stall = s[0];
    for (int th = 0; th < 2; th++) begin
      for (int l = 0; l < 4; l++) begin
        if (qh[th] + l < qlen[th]) begin
          in_vld[th*4+l]      = 1'b1;
          in_op[(th*4+l)*4 +: 4] = 4'(qop[th][qh[th]+l]);
        end else begin
          in_vld[th*4+l]      = 1'b0;
          in_op[(th*4+l)*4 +: 4] = 4'd0;
        end
      end
    end
    #1;
    chk("R2", int'(cur_tid), m_tid, "cur_tid");
    t = m_tid;
    for (int l = 0; l < 4; l++) begin
      v[l] = (qh[t] + l < qlen[t]) ? 1 : 0;
      o[l] = v[l] ? qop[t][qh[t]+l] : 0;
    end
    take = 0;
    ttag = "R9";
    if (s != 0) begin
      ttag  = "R8";
      e_tag = "R8";
    end else if (m_busy != 0) begin
      ttag = "R7";
      clear_exp();
      rem = ms_len(m_op) - 4 * m_step;
      cnt = (rem > 4) ? 4 : rem;
      for (int j = 0; j < cnt; j++) begin
        e_vld[j] = 1; e_op[j] = m_op; e_idx[j] = 4 * m_step + j;
      end
      e_tid = m_stid;
      e_tag = "R6";
      m_seqc++;
      if (rem <= 4) begin
        m_busy = 0;
        chk("R6", m_seqc, (ms_len(m_op) + 3) / 4, "sequence cycle count");
      end else begin
        m_step++;
      end
    end else begin
      clear_exp();
      e_tid = m_tid;
      e_tag = "R3";
      if (v[0] != 0) begin
        take = 1;
        if (o[0] >= 13) begin
          n = ms_len(o[0]);
          cnt = (n > 4) ? 4 : n;
          for (int j = 0; j < cnt; j++) begin
            e_vld[j] = 1; e_op[j] = o[0]; e_idx[j] = j;
          end
          e_tag = "R6";
          ttag = (v[1] != 0) ? "R6" : "R9";
          m_seqc = 1;
          m_busy = 1; m_step = 1; m_op = o[0]; m_stid = m_tid;
        end else begin
          k = ops_of(o[0]);
          for (int j = 0; j < k; j++) begin
            e_vld[j] = 1; e_op[j] = o[0]; e_idx[j] = j;
          end
          go = 1;
          for (int i = 1; i < 4; i++) begin
            if (go != 0 && i <= 4 - k && v[i] != 0 && o[i] < 8) begin
              e_vld[k+i-1] = 1; e_op[k+i-1] = o[i]; e_idx[k+i-1] = 0;
              take++;
              e_tag = "R4";
            end else if (go != 0) begin
              go = 0;
              if (v[i] != 0) ttag = (i > 4 - k) ? "R4" : "R5";
            end
          end
        end
      end
      m_tid = 1 - m_tid;
    end
    chk(ttag, int'(take_cnt), take, "take_cnt");
    qh[t] += take;
    @(negedge clk);
  endtask

  initial begin
    int d0[16] = '{0, 1, 2, 3, 12, 5, 6, 7, 10, 4, 5, 6, 1, 9, 2, 3};
    int d1[16] = '{8, 1, 2, 3, 13, 0, 11, 2, 14, 3, 4, 15, 5, 6, 7, 0};
    int cyc;
    qlen[0] = 200; qlen[1] = 160; qh[0] = 0; qh[1] = 0;
    for (int i = 0; i < 256; i++) begin
      qop[0][i] = (i < 16) ? d0[i] : ((i * 5 + i / 7) % 16);
      qop[1][i] = (i < 16) ? d1[i] : ((i * 11 + 3 + i / 5) % 16);
    end
    in_vld = '0; in_op = '0; out_stall = 1'b0;
    m_tid = 0; m_busy = 0; m_op = 0; m_step = 0; m_stid = 0; m_seqc = 0;
    clear_exp(); e_tid = 0; e_tag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", int'(out_vld), 0, "out_vld in reset");
    chk("R1", int'(cur_tid), 0, "cur_tid in reset");
    chk("R1", int'(out_tid), 0, "out_tid in reset");
    chk("R1", int'(take_cnt), 0, "take_cnt in reset");
    rst = 1'b0;
    cyc = 0;
    while ((qh[0] < qlen[0] || qh[1] < qlen[1] || m_busy != 0) && cyc < 4000) begin
      run_cycle(cyc);
      cyc++;
    end
    // R9: both windows empty
    for (int x = 0; x < 3; x++) begin
      run_cycle(cyc);
      cyc++;
    end
    check_bundle();
    chk("R9", qh[0], qlen[0], "thread 0 drained");
    chk("R9", qh[1], qlen[1], "thread 1 drained");
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule